// File: doc/BRIEF.md
# Character Display Memory Address Selector

This block produces the 10-bit address of a 1024-entry, 8-bit character display memory laid out as 16 rows of 64 characters. Two sources compete for the memory. One is an address presented by the processor bus. The other is a refresh address generated inside the block.

The refresh address has two parts. The column part is a 6-bit character-position counter. It is built from two 3-bit stages in cascade: a fine stage and a coarse stage. The counter steps once per character clock while the horizontal display window is open. The row part is a 4-bit base-row counter. At each frame start it loads a scroll offset, and it then steps modulo 16 on each character-row advance. Because of this, the first displayed line can be any memory row, and the rows rotate through memory to give hardware scrolling.

A select line steers every address bit to one source or the other. The refresh counters keep running while the bus owns the memory, so refresh timing is never disturbed. The memory enable output is held permanently active. All pins are plain control and address pins. Nothing flows as a stream, so there is no handshake and no back-pressure.

Top module: `vram_addr_mux`

## Requirements
- R1: After reset the column and base-row counters are zero, so with bus_sel low the address is 0.
- R2: With bus_sel high, mem_addr equals bus_addr in the same cycle: bits [5:0] give the character position and bits [9:6] give the row.
- R3: With bus_sel low, mem_addr[5:0] is the column counter and mem_addr[9:6] is the base-row counter.
- R4: The column counter rises by one on each clock edge where char_en is high, and holds when char_en is low.
- R5: The column counter is a 3-bit fine stage (bits [2:0]) that carries into a 3-bit coarse stage (bits [5:3]), so 7 steps to 8 and 63 wraps to 0.
- R6: line_start clears the column counter on the next edge and takes priority over char_en.
- R7: frame_start loads scroll_row into the base-row counter on the next edge.
- R8: row_step increments the base-row counter modulo 16, so 15 wraps to 0.
- R9: When frame_start and row_step are both high, the load wins and the counter takes scroll_row.
- R10: While bus_sel is high, both counters keep counting exactly as when it is low.
- R11: mem_en is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_en | input | 1 | Horizontal display window open; column counter steps |
| line_start | input | 1 | Start of scan line; clears the column counter |
| row_step | input | 1 | Character-row advance strobe |
| frame_start | input | 1 | Start of frame; loads scroll_row |
| scroll_row | input | 4 | First memory row to display |
| bus_addr | input | 10 | Processor bus address |
| bus_sel | input | 1 | 1 selects bus_addr, 0 selects the refresh address |
| mem_addr | output | 10 | Display memory address |
| mem_en | output | 1 | Memory enable, always 1 |

## Verification
Two pairs of functions can land in the same cycle. A column clear can coincide with a column step, and a scroll load can coincide with a row advance. The bench drives both pairs on purpose: line_start together with char_en, and frame_start together with row_step. It then checks that the counters take the cleared value or the loaded value, not the stepped one. During the randomized phase, all strobes and the select line also toggle freely and overlap. A behavioural model, updated on every clock, gives the expected address in each cycle.

// File: rtl/vram_pkg.sv
package vram_pkg;
  localparam int unsigned COL_STAGES  = 2;
  localparam int unsigned COL_STAGE_W = 3;
  localparam int unsigned ROW_W       = 4;
  localparam int unsigned COL_W       = COL_STAGES * COL_STAGE_W;
  localparam int unsigned ADDR_W      = COL_W + ROW_W;
endpackage

// File: rtl/vram_col_counter.sv
module vram_col_counter #(
  parameter int unsigned NUM_STAGES = vram_pkg::COL_STAGES,
  parameter int unsigned STAGE_W    = vram_pkg::COL_STAGE_W,
  localparam int unsigned COL_W     = NUM_STAGES * STAGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [COL_W-1:0] col
);
  logic [NUM_STAGES-1:0] carry;
  assign carry[0] = adv;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic [STAGE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (clr)      q <= '0;
      else if (carry[g]) q <= q + 1'b1;
    end
    assign col[g*STAGE_W +: STAGE_W] = q;
    if (g < NUM_STAGES - 1) begin : g_carry
      assign carry[g+1] = carry[g] && (q == {STAGE_W{1'b1}});
    end
  end

  AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (col == '0)); // R6
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && adv) |=> (col == COL_W'($past(col) + 1'b1))); // R4
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(col)); // R4
  AST_COL_FINE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && adv && col[STAGE_W-1:0] == {STAGE_W{1'b1}}) |=> (col[STAGE_W-1:0] == '0)); // R5
endmodule

// File: rtl/vram_row_base.sv
module vram_row_base #(
  parameter int unsigned ROW_W = vram_pkg::ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] load_val,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n)    row <= '0;
    else if (load) row <= load_val;
    else if (adv)  row <= row + 1'b1;
  end

  AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (row == $past(load_val))); // R7
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> (row == ROW_W'($past(row) + 1'b1))); // R8
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(row)); // R8
endmodule

// File: rtl/vram_addr_select.sv
module vram_addr_select #(
  parameter int unsigned ADDR_W = vram_pkg::ADDR_W
) (
  input  logic              sel_ext,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] int_addr,
  output logic [ADDR_W-1:0] addr
);
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    assign addr[b] = sel_ext ? ext_addr[b] : int_addr[b];
  end
endmodule

// File: rtl/vram_addr_mux.sv
module vram_addr_mux #(
  parameter int unsigned COL_STAGES  = vram_pkg::COL_STAGES,
  parameter int unsigned COL_STAGE_W = vram_pkg::COL_STAGE_W,
  parameter int unsigned ROW_W       = vram_pkg::ROW_W,
  localparam int unsigned COL_W      = COL_STAGES * COL_STAGE_W,
  localparam int unsigned ADDR_W     = COL_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_en,
  input  logic              line_start,
  input  logic              row_step,
  input  logic              frame_start,
  input  logic [ROW_W-1:0]  scroll_row,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en
);
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  vram_col_counter #(.NUM_STAGES(COL_STAGES), .STAGE_W(COL_STAGE_W)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(line_start), .adv(char_en), .col(col_q)
  );

  vram_row_base #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .load_val(scroll_row),
    .adv(row_step), .row(row_q)
  );

  vram_addr_select #(.ADDR_W(ADDR_W)) u_sel (
    .sel_ext(bus_sel), .ext_addr(bus_addr), .int_addr({row_q, col_q}),
    .addr(mem_addr)
  );

  assign mem_en = 1'b1;

  AST_BUS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> (mem_addr == bus_addr)); // R2
  AST_REFRESH_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !line_start && char_en) |=> (col_q == COL_W'($past(col_q) + 1'b1))); // R10
endmodule

// File: tb/test_vram_addr_mux.sv
module test_vram_addr_mux;
  logic clk = 1'b0;
  logic rst_n;
  logic char_en, line_start, row_step, frame_start, bus_sel;
  logic [3:0] scroll_row;
  logic [9:0] bus_addr;
  logic [9:0] mem_addr;
  logic mem_en;

  int n_tests = 0;
  int n_fail  = 0;
  int m_col = 0;
  int m_row = 0;

  always #2 clk = ~clk;

  vram_addr_mux i_vram_addr_mux (
    .clk(clk), .rst_n(rst_n), .char_en(char_en), .line_start(line_start),
    .row_step(row_step), .frame_start(frame_start), .scroll_row(scroll_row),
    .bus_addr(bus_addr), .bus_sel(bus_sel), .mem_addr(mem_addr), .mem_en(mem_en)
  );

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at negedge, compare 1 ns later, then advance the model at posedge
  task automatic step(string tag, bit ce, bit ls, bit fs, bit rs,
                      int scr, bit sel, int ea);
    int exp;
    @(negedge clk);
    char_en = ce; line_start = ls; frame_start = fs; row_step = rs;
    scroll_row = scr[3:0]; bus_sel = sel; bus_addr = ea[9:0];
    #1;
    exp = sel ? (ea % 1024) : (m_row * 64 + m_col);
    check(tag, int'(mem_addr), exp);
    check("R11", int'(mem_en), 1);
    @(posedge clk);
    if (ls) m_col = 0; else if (ce) m_col = (m_col + 1) % 64;
    if (fs) m_row = scr % 16; else if (rs) m_row = (m_row + 1) % 16;
  endtask

  task automatic idle_check(string tag, int exp);
    @(negedge clk);
    char_en = 0; line_start = 0; frame_start = 0; row_step = 0; bus_sel = 0;
    #1;
    check(tag, int'(mem_addr), exp);
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; char_en = 0; line_start = 0; row_step = 0; frame_start = 0;
    bus_sel = 0; scroll_row = 0; bus_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    m_col = 0; m_row = 0;
    idle_check("R1", 0);

    // R4: step ten times, then hold
    for (int i = 0; i < 10; i++) step("R4", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++)  step("R4", 0, 0, 0, 0, 0, 0, 0);
    idle_check("R4", 10);

    // R5: cross fine-stage carry and wrap 63 -> 0
    for (int i = 0; i < 60; i++) step("R5", 1, 0, 0, 0, 0, 0, 0);
    idle_check("R5", 6); // 70 mod 64

    // R6: clear wins over step
    step("R6", 1, 1, 0, 0, 0, 0, 0);
    idle_check("R6", 0);

    // R7 and R8: load 13, advance three times, wrapping past 15
    step("R7", 0, 0, 1, 0, 13, 0, 0);
    idle_check("R7", 13 * 64);
    for (int i = 0; i < 3; i++) step("R8", 0, 0, 0, 1, 0, 0, 0);
    idle_check("R8", 0);

    // R9: load and advance together
    step("R9", 0, 0, 1, 1, 5, 0, 0);
    idle_check("R9", 5 * 64);

    // R2 and R10: bus owns memory while refresh keeps counting
    for (int i = 0; i < 20; i++)
      step("R2", 1, 0, 0, (i % 5) == 0, 0, 1, (i * 53 + 7) % 1024);
    idle_check("R10", 9 * 64 + 20);

    // R3: randomized overlap of every strobe and the select line
    for (int i = 0; i < 400; i++) begin
      automatic int r = int'($urandom);
      step("R3", r[0] | r[1], r[2] & r[3] & r[4], r[5] & r[6] & r[7],
           r[8] & r[9], (r >> 10) & 15, r[14] & r[15], (r >> 16) & 1023);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule